// File: doc/BRIEF.md
# Latching Fault and Under-Voltage Supervisor

This block decides, every clock, whether the switching stage of an offline power converter may run and whether the high-voltage startup current source should charge the supply capacitor. It works only on digitised comparator flags. The supply rail is reported against five levels (4, 6, 9, 12 and 28 V). The other flags are feedback-above-overload-level, external-latch-pin-high, over-temperature and line brown-in good. The analog comparators and their hysteresis sit outside the block.

Start-up is a classic under-voltage lockout. The startup source charges the rail until it crosses 12 V, and the block then runs until the rail sags below 6 V. While running, four fault conditions are watched, each through its own consecutive-cycle debounce counter. Any fault that survives its debounce window latches. Switching then stops for good, and the first cause is held in a fault code. While latched, the startup source keeps the rail bouncing between 9 V and 12 V. Only a collapse of the rail below 4 V, which means the line has gone away, clears the latch. The next start again needs the 12 V crossing.

Top module: `fault_uvlo_supervisor`

## Requirements
- R1: While reset is held, sw_en is 0, hv_en is 1 and fault_code is 0.
- R2: When stopped and unlatched, hv_en stays 1 until a clock edge samples vdd_gt12 high. At that edge the block enters the running state, and hv_en goes to 0 after it.
- R3: While running, a clock edge that samples vdd_gt6 low returns the block to the stopped state with hv_en 1. A new start needs vdd_gt12 again, so a rail between 6 and 12 V does not restart it.
- R4: sw_en is 1 only while running with brown_ok and vdd_gt6 both high and no fault latched. Dropping brown_ok clears sw_en in the same cycle without changing any state.
- R5: Overload: fb_gt_olp high on OLP_CYC consecutive running edges latches a fault with fault_code 1.
- R6: Over-voltage: vdd_gt28 high on OVP_CYC consecutive running edges latches fault_code 2.
- R7: External latch: ext_latch_hi high on EXT_CYC consecutive running edges latches fault_code 3.
- R8: Over-temperature: temp_hot high on HOT_CYC consecutive running edges latches fault_code 4.
- R9: A debounce count restarts from zero when its condition is low on any edge before the window completes.
- R10: Once latched, sw_en stays 0 and fault_code keeps the first cause, even after the fault condition goes away and even if other fault inputs rise.
- R11: When several faults complete their windows on the same edge, the code recorded follows the priority over-voltage (2), then over-temperature (4), then external latch (3), then overload (1).
- R12: While latched, an edge that samples vdd_gt9 low sets hv_en to 1, and an edge that samples vdd_gt12 high clears it. Between those levels hv_en holds its value.
- R13: While latched, an edge that samples vdd_gt4 low clears fault_code to 0 and sets hv_en to 1. A normal start from 12 V may then follow.
- R14: Debounce counters advance only in the running state. Fault inputs held while stopped or latched neither trip the block nor shorten a later window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vdd_gt4 | input | 1 | Supply above the 4 V latch-release level |
| vdd_gt6 | input | 1 | Supply above the 6 V stop level |
| vdd_gt9 | input | 1 | Supply above the 9 V hiccup-low level |
| vdd_gt12 | input | 1 | Supply above the 12 V start level |
| vdd_gt28 | input | 1 | Supply above the 28 V over-voltage level |
| fb_gt_olp | input | 1 | Feedback above the overload level |
| ext_latch_hi | input | 1 | External latch pin above its reference |
| temp_hot | input | 1 | Over-temperature flag, hysteresis applied outside |
| brown_ok | input | 1 | Line voltage above the brown-in level |
| sw_en | output | 1 | Switching allowed |
| hv_en | output | 1 | High-voltage startup source on |
| fault_code | output | 3 | First latched cause: 0 none, 1 overload, 2 over-voltage, 3 external, 4 over-temperature |

## Verification
A debounce counter that counts wrong, or that is not cleared, moves the drop of sw_en one or more edges away from the exact window length, so the bench samples the edge before and the edge at the window's end. A wrong control state appears on hv_en or sw_en one edge after the supply flags that should have moved it. Errors of this kind are start-up from a level below 12 V, a missing hiccup, or a latch that survives a rail above 4 V. A wrong capture or priority is visible at once on fault_code, and because the code is sticky it stays visible until the rail collapses.

// File: rtl/sup_pkg.sv
// Package: shared types for the fault / under-voltage supervisor.
// Assumes fault index order OLP, OVP, EXT, HOT in every fault vector.
package sup_pkg;

    localparam int NUM_FAULTS = 4;
    localparam int IDX_OLP    = 0;
    localparam int IDX_OVP    = 1;
    localparam int IDX_EXT    = 2;
    localparam int IDX_HOT    = 3;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_LATCH = 2'd2
    } sup_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_OLP  = 3'd1,
        CAUSE_OVP  = 3'd2,
        CAUSE_EXT  = 3'd3,
        CAUSE_HOT  = 3'd4
    } cause_e;

    // Priority pick among simultaneous trips: OVP, HOT, EXT, OLP.
    function automatic cause_e pick_cause(input logic [NUM_FAULTS-1:0] trip);
        cause_e c;
        c = CAUSE_NONE;
        if (trip[IDX_OVP])      c = CAUSE_OVP;
        else if (trip[IDX_HOT]) c = CAUSE_HOT;
        else if (trip[IDX_EXT]) c = CAUSE_EXT;
        else if (trip[IDX_OLP]) c = CAUSE_OLP;
        return c;
    endfunction

endpackage

// File: rtl/sup_debounce.sv
// Module: consecutive-cycle debounce for one fault flag.
// Raises trip on the N-th consecutive enabled edge with cond high.
// Assumes N >= 1; the count restarts whenever cond or en is low.
module sup_debounce #(
    parameter int unsigned N = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cond,
    output logic trip
);
    localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt;

    // Count consecutive qualified edges, saturating at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (!(en && cond))   cnt <= '0;
        else if (cnt != LAST)     cnt <= cnt + CW'(1);
    end

    // Window complete when the condition is still present at LAST.
    always_comb trip = en && cond && (cnt == LAST);

endmodule

// File: rtl/sup_cause_reg.sv
// Module: sticky first-fault cause register.
// Captures the highest-priority trip while armed and empty; clears on release.
module sup_cause_reg
    import sup_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  logic                  release_req,
    input  logic [NUM_FAULTS-1:0] trip,
    output cause_e                cause
);
    // Hold the first cause until the latch is released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause <= CAUSE_NONE;
        else if (release_req)
            cause <= CAUSE_NONE;
        else if (arm && (cause == CAUSE_NONE) && (|trip))
            cause <= pick_cause(trip);
    end

endmodule

// File: rtl/sup_uvlo_fsm.sv
// Module: lockout / run / latch state machine with startup-source control.
// Assumes supply flags are monotonic (gt12 implies gt9 implies gt6 implies gt4).
module sup_uvlo_fsm
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vdd_gt4,
    input  logic       vdd_gt6,
    input  logic       vdd_gt9,
    input  logic       vdd_gt12,
    input  logic       any_trip,
    output sup_state_e state,
    output logic       hv_en
);
    sup_state_e state_nx;
    logic       hv_nx;

    // Next state and next startup-source value.
    always_comb begin
        state_nx = state;
        hv_nx    = hv_en;
        case (state)
            ST_OFF: begin
                if (vdd_gt12) begin
                    state_nx = ST_RUN;
                    hv_nx    = 1'b0;
                end else begin
                    hv_nx    = 1'b1;
                end
            end
            ST_RUN: begin
                if (any_trip) begin
                    state_nx = ST_LATCH;
                    hv_nx    = !vdd_gt9;
                end else if (!vdd_gt6) begin
                    state_nx = ST_OFF;
                    hv_nx    = 1'b1;
                end else begin
                    hv_nx    = 1'b0;
                end
            end
            ST_LATCH: begin
                if (!vdd_gt4) begin
                    state_nx = ST_OFF;
                    hv_nx    = 1'b1;
                end else if (vdd_gt12) begin
                    hv_nx    = 1'b0;
                end else if (!vdd_gt9) begin
                    hv_nx    = 1'b1;
                end
            end
            default: begin
                state_nx = ST_OFF;
                hv_nx    = 1'b1;
            end
        endcase
    end

    // State and startup-source registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            hv_en <= 1'b1;
        end else begin
            state <= state_nx;
            hv_en <= hv_nx;
        end
    end

endmodule

// File: rtl/fault_uvlo_supervisor.sv
// Module: top of the latching fault and under-voltage supervisor.
// Debounces four fault flags while running, latches the first cause,
// gates switching and drives the startup source (start, hiccup, release).
// Assumes all inputs are already synchronous to clk.
module fault_uvlo_supervisor
    import sup_pkg::*;
#(
    parameter int unsigned OLP_CYC = 2800000,
    parameter int unsigned OVP_CYC = 7500,
    parameter int unsigned EXT_CYC = 1750,
    parameter int unsigned HOT_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vdd_gt4,
    input  logic       vdd_gt6,
    input  logic       vdd_gt9,
    input  logic       vdd_gt12,
    input  logic       vdd_gt28,
    input  logic       fb_gt_olp,
    input  logic       ext_latch_hi,
    input  logic       temp_hot,
    input  logic       brown_ok,
    output logic       sw_en,
    output logic       hv_en,
    output logic [2:0] fault_code
);
    logic [NUM_FAULTS-1:0] fault_raw;
    logic [NUM_FAULTS-1:0] trip;
    sup_state_e            state;
    cause_e                cause;
    logic                  running;
    logic                  release_req;

    // Gather raw fault flags in package index order.
    always_comb begin
        fault_raw          = '0;
        fault_raw[IDX_OLP] = fb_gt_olp;
        fault_raw[IDX_OVP] = vdd_gt28;
        fault_raw[IDX_EXT] = ext_latch_hi;
        fault_raw[IDX_HOT] = temp_hot;
    end

    always_comb running     = (state == ST_RUN);
    always_comb release_req = (state == ST_LATCH) && !vdd_gt4;

    for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_db
        localparam int unsigned WIN = (g == IDX_OLP) ? OLP_CYC :
                                      (g == IDX_OVP) ? OVP_CYC :
                                      (g == IDX_EXT) ? EXT_CYC : HOT_CYC;
        sup_debounce #(.N(WIN)) i_db (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (running),
            .cond (fault_raw[g]),
            .trip (trip[g])
        );
    end

    sup_cause_reg i_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (running),
        .release_req(release_req),
        .trip       (trip),
        .cause      (cause)
    );

    sup_uvlo_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .vdd_gt4 (vdd_gt4),
        .vdd_gt6 (vdd_gt6),
        .vdd_gt9 (vdd_gt9),
        .vdd_gt12(vdd_gt12),
        .any_trip(|trip),
        .state   (state),
        .hv_en   (hv_en)
    );

    // Switching allowed only while running on a good rail and line.
    always_comb sw_en = running && brown_ok && vdd_gt6;
    always_comb fault_code = cause;

endmodule

// File: rtl/fault_uvlo_supervisor_chk.sv
// Module: assertion checker bound to the supervisor top.
// Assumes monotonic supply flags, as the top does.
module fault_uvlo_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vdd_gt4,
    input logic       vdd_gt6,
    input logic       vdd_gt9,
    input logic       vdd_gt12,
    input logic       vdd_gt28,
    input logic       fb_gt_olp,
    input logic       ext_latch_hi,
    input logic       temp_hot,
    input logic       brown_ok,
    input logic       sw_en,
    input logic       hv_en,
    input logic [2:0] fault_code
);
    p_sw_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |-> (brown_ok && vdd_gt6 && fault_code == 3'd0));

    p_cause_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 3'd0 && vdd_gt4) |=> (fault_code == $past(fault_code)));

    p_release_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 3'd0 && !vdd_gt4) |=> (fault_code == 3'd0 && hv_en));

    p_hiccup_on_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 3'd0 && vdd_gt4 && !vdd_gt9) |=> hv_en);

    p_hiccup_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_gt12 |=> !hv_en);

    p_no_sw_with_hv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en |-> !hv_en);

endmodule

bind fault_uvlo_supervisor fault_uvlo_supervisor_chk i_chk (.*);

// File: tb/test_fault_uvlo_supervisor.sv
module test_fault_uvlo_supervisor;
    localparam int OLP_N = 10;
    localparam int OVP_N = 6;
    localparam int EXT_N = 4;
    localparam int HOT_N = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic g4, g6, g9, g12, g28, fb, lh, hot, bok;
    logic sw_en, hv_en;
    logic [2:0] fault_code;
    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fault_uvlo_supervisor #(
        .OLP_CYC(OLP_N), .OVP_CYC(OVP_N), .EXT_CYC(EXT_N), .HOT_CYC(HOT_N)
    ) i_fault_uvlo_supervisor (
        .clk(clk), .rst_n(rst_n),
        .vdd_gt4(g4), .vdd_gt6(g6), .vdd_gt9(g9), .vdd_gt12(g12), .vdd_gt28(g28),
        .fb_gt_olp(fb), .ext_latch_hi(lh), .temp_hot(hot), .brown_ok(bok),
        .sw_en(sw_en), .hv_en(hv_en), .fault_code(fault_code)
    );

    // Vector: {volts[4:0], brown, fb, lh, hot, exp_sw, exp_hv, exp_code[2:0], req[3:0]}
    localparam int TN = 27;
    localparam logic [17:0] TBL [0:TN-1] = '{
        {5'd8,  4'b1000, 2'b01, 3'd0, 4'd2},   // R2 wait below 12
        {5'd12, 4'b1000, 2'b10, 3'd0, 4'd2},   // R2 start
        {5'd15, 4'b0000, 2'b00, 3'd0, 4'd4},   // R4 brown-in lost
        {5'd15, 4'b1000, 2'b10, 3'd0, 4'd4},   // R4 back
        {5'd5,  4'b1000, 2'b01, 3'd0, 4'd3},   // R3 stop below 6
        {5'd10, 4'b1000, 2'b01, 3'd0, 4'd3},   // R3 no restart below 12
        {5'd12, 4'b1000, 2'b10, 3'd0, 4'd2},   // R2 restart
        {5'd15, 4'b1001, 2'b10, 3'd0, 4'd8},   // R8 hot edge 1
        {5'd15, 4'b1001, 2'b10, 3'd0, 4'd8},   // R8 hot edge 2
        {5'd15, 4'b1001, 2'b00, 3'd4, 4'd8},   // R8 trip
        {5'd15, 4'b1000, 2'b00, 3'd4, 4'd10},  // R10 stays latched
        {5'd15, 4'b1010, 2'b00, 3'd4, 4'd14},  // R14 lh ignored when latched
        {5'd8,  4'b1000, 2'b01, 3'd4, 4'd12},  // R12 source on below 9
        {5'd10, 4'b1000, 2'b01, 3'd4, 4'd12},  // R12 hold
        {5'd12, 4'b1000, 2'b00, 3'd4, 4'd12},  // R12 off at 12
        {5'd10, 4'b1000, 2'b00, 3'd4, 4'd12},  // R12 hold
        {5'd8,  4'b1000, 2'b01, 3'd4, 4'd12},  // R12 on again
        {5'd3,  4'b1000, 2'b01, 3'd0, 4'd13},  // R13 release
        {5'd12, 4'b1000, 2'b10, 3'd0, 4'd13},  // R13 restart
        {5'd15, 4'b1010, 2'b10, 3'd0, 4'd9},   // R9 lh 1
        {5'd15, 4'b1010, 2'b10, 3'd0, 4'd9},   // R9 lh 2
        {5'd15, 4'b1000, 2'b10, 3'd0, 4'd9},   // R9 dropout
        {5'd15, 4'b1010, 2'b10, 3'd0, 4'd9},   // R9 lh 1
        {5'd15, 4'b1010, 2'b10, 3'd0, 4'd9},   // R9 lh 2
        {5'd15, 4'b1010, 2'b10, 3'd0, 4'd9},   // R9 lh 3
        {5'd15, 4'b1010, 2'b00, 3'd3, 4'd7},   // R7 trip after full window
        {5'd3,  4'b1000, 2'b01, 3'd0, 4'd13}   // R13 release
    };

    task automatic set_v(input int v);
        g4 = (v >= 4); g6 = (v >= 6); g9 = (v >= 9);
        g12 = (v >= 12); g28 = (v >= 28);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int esw, input int ehv, input int ec);
        chk(req, "sw_en", int'(sw_en), esw);
        chk(req, "hv_en", int'(hv_en), ehv);
        chk(req, "fault_code", int'(fault_code), ec);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        set_v(0); fb = 0; lh = 0; hot = 0; bok = 1;
        repeat (3) @(negedge clk);
        chk_all("R1", 0, 1, 0);
        rst_n = 1'b1;

        for (int i = 0; i < TN; i++) begin
            logic [17:0] t;
            t = TBL[i];
            set_v(int'(t[17:13]));
            bok = t[12]; fb = t[11]; lh = t[10]; hot = t[9];
            step();
            chk_all($sformatf("R%0d step %0d", t[3:0], i),
                    int'(t[8]), int'(t[7]), int'(t[6:4]));
        end

        // R5 overload window
        bok = 1; lh = 0; hot = 0; fb = 0;
        set_v(12); step();
        set_v(15); fb = 1;
        repeat (OLP_N - 1) step();
        chk_all("R5 before window", 1, 0, 0);
        step();
        chk_all("R5 trip", 0, 0, 1);
        fb = 0; set_v(3); step();

        // R6 over-voltage window
        set_v(12); step();
        set_v(30);
        repeat (OVP_N - 1) step();
        chk_all("R6 before window", 1, 0, 0);
        step();
        chk_all("R6 trip", 0, 0, 2);
        set_v(3); step();

        // R11 OVP and HOT complete on the same edge
        set_v(12); step();
        set_v(30);
        repeat (OVP_N - HOT_N) step();
        hot = 1;
        repeat (HOT_N) step();
        chk_all("R11 ovp over hot", 0, 0, 2);
        hot = 0; set_v(3); step();

        // R11 HOT and EXT complete on the same edge
        set_v(12); step();
        set_v(15); lh = 1;
        repeat (EXT_N - HOT_N) step();
        hot = 1;
        repeat (HOT_N) step();
        chk_all("R11 hot over ext", 0, 0, 4);
        hot = 0; lh = 0; set_v(3); step();

        // R11 EXT and OLP complete on the same edge
        set_v(12); step();
        set_v(15); fb = 1;
        repeat (OLP_N - EXT_N) step();
        lh = 1;
        repeat (EXT_N) step();
        chk_all("R11 ext over olp", 0, 0, 3);
        fb = 0; lh = 0; set_v(3); step();

        // R14 faults held while stopped neither trip nor pre-count
        set_v(8); fb = 1; hot = 1;
        repeat (20) step();
        chk_all("R14 stopped with faults", 0, 1, 0);
        hot = 0; set_v(12); step();
        chk_all("R14 start", 1, 0, 0);
        repeat (OLP_N - 1) step();
        chk_all("R14 full window still needed", 1, 0, 0);
        step();
        chk_all("R14 trip after window", 0, 0, 1);

        // R1 reset mid-fault
        rst_n = 1'b0; step();
        chk_all("R1 reset while latched", 0, 1, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule